// File: doc/BRIEF.md
# Data Frame Packetiser with Hang Bit

This block turns one transmitted data frame into a serial bit stream for a downstream modulator. A frame opens with two fixed 16-bit synchronisation words. Four control bytes follow: an address byte, a format byte, a size-or-user byte and a check byte over those three. User data bytes, pulled one at a time from a FIFO-style source, come next. When the frame carries a sized data block, a CRC over the user data closes it. Every frame ends with a single hang bit, and then the output goes quiet.

The host presents the three control bytes and the sized flag, then pulses `start`. It keeps the data FIFO supplied and raises `last_data` once it has loaded the final byte. At each byte boundary the block takes the next byte if one is waiting. If the FIFO is empty and `last_data` is set, it moves on to the trailer. If the FIFO is empty and `last_data` is clear, it flags an underrun and closes the frame with the hang bit. The modulator side is a valid/ready handshake carrying one bit per accepted transfer. An optional interrupt pulse marks the moment the hang bit has left.

Top module: `frame_tx_packer`

## Requirements
- R1: While reset is held, and on the first cycle after it, `bit_valid`, `busy`, `irq`, `din_ready` and `underrun` are all low.
- R2: The first 32 bits of a frame are `BIT_SYNC` followed by `FRAME_SYNC`, each sent MSB first.
- R3: Bits 32 to 63 carry, MSB first and in this order, the address byte, the format byte, the size byte and a check byte chosen so that the four bytes add to zero modulo 256.
- R4: The user data bytes follow the control bytes MSB first, in FIFO order. Exactly one byte is popped per `din_valid && din_ready` cycle, and `din_ready` is never high when `din_valid` is low.
- R5: When `sized` was 1 at start and the frame ends through `last_data`, a CRC follows the data. It is non-reflected, MSB first, uses an all-ones initial value and has no final XOR. It is 16 bits (polynomial 0x1021) when the frame held 16 or fewer data bytes, and 32 bits (polynomial 0x04C11DB7) when it held more. When `sized` was 0, no CRC is sent.
- R6: The last bit of every frame is a hang bit whose value is the inverse of the bit sent just before it. After the hang bit is accepted, `bit_valid` and `busy` go low.
- R7: When `irq_en` is 1, `irq` is high for exactly one cycle, in the cycle after the hang bit is accepted. When `irq_en` is 0, `irq` stays low.
- R8: If the FIFO is empty at a byte boundary while `last_data` is 0, `underrun` goes high and stays high until the next start. No CRC is sent, and the hang bit follows at once.
- R9: While `bit_valid` is high and `bit_ready` is low, `bit_out` and `bit_valid` hold their values into the next cycle.
- R10: A `start` pulse while `busy` is high has no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a frame; sampled only when idle |
| addr_byte | input | 8 | Address control byte |
| fmt_byte | input | 8 | Format control byte |
| size_byte | input | 8 | Size or user control byte |
| sized | input | 1 | 1 = sized data block, so a data CRC is appended |
| last_data | input | 1 | Host has loaded the final data byte |
| irq_en | input | 1 | Enable the end-of-frame interrupt |
| din | input | 8 | Data byte at the head of the FIFO |
| din_valid | input | 1 | FIFO holds at least one byte |
| din_ready | output | 1 | Pop strobe for the FIFO head |
| bit_out | output | 1 | Serial bit toward the modulator |
| bit_valid | output | 1 | `bit_out` is valid |
| bit_ready | input | 1 | Modulator accepts the bit |
| irq | output | 1 | One-cycle pulse after the hang bit leaves |
| underrun | output | 1 | Frame closed because the FIFO ran dry |
| busy | output | 1 | A frame is in progress |

## Verification
Any wrong internal state shows up in the bit stream. A wrong field counter or state shifts every later bit. A wrong CRC width or value corrupts the tail of a sized frame. A wrong remembered last bit makes the hang bit come out with the wrong polarity. All of these appear at `bit_out` within one field of 8 to 32 accepted bits. The bench compares each whole stream against a model built from the requirements. It includes frames at exactly 16 and 17 data bytes, an empty sized frame, a frame that runs dry, and throttled `bit_ready` patterns, so that off-by-one boundary decisions and handshake stalls surface within the frame in which they occur.

// File: rtl/ftx_pkg.sv
// Package ftx_pkg
// Shared types and helpers for the frame packetiser.
// Assumes: control bytes are 8 bits wide.
package ftx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_HEAD,
        ST_DATA,
        ST_CSUM,
        ST_HANG
    } ftx_state_e;

    // Check byte that makes the four control bytes add to zero mod 256
    function automatic logic [7:0] head_check(input logic [7:0] a,
                                              input logic [7:0] f,
                                              input logic [7:0] s);
        logic [7:0] t;
        t = a + f + s;
        return (~t) + 8'd1;
    endfunction

endpackage

// File: rtl/ftx_crc_serial.sv
// Module ftx_crc_serial
// Bit-serial CRC, non-reflected, MSB first, no final XOR.
// Exposes the registered value and the value after the current bit, so the
// caller can load the finished CRC on the same edge as the final data bit.
// Assumes: clear and shift_en are not asserted together.
module ftx_crc_serial #(
    parameter int               WIDTH = 16,
    parameter logic [WIDTH-1:0] POLY  = '0,
    parameter logic [WIDTH-1:0] INIT  = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] crc,
    output logic [WIDTH-1:0] crc_nxt
);
    logic feedback;

    // Next value: one LFSR step when shifting, otherwise hold
    always_comb begin
        feedback = crc[WIDTH-1] ^ bit_in;
        if (shift_en)
            crc_nxt = {crc[WIDTH-2:0], 1'b0} ^ (feedback ? POLY : '0);
        else
            crc_nxt = crc;
    end

    // Register: reset and clear to INIT, else take the next value
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            crc <= INIT;
        else
            crc <= crc_nxt;
    end

    // A clear must leave the register at the initial value
    AST_CRC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> crc == INIT);  // R5

endmodule

// File: rtl/ftx_len_track.sv
// Module ftx_len_track
// Counts user data bytes popped in a frame (saturating) and reports when the
// count exceeds SHORT_MAX, which selects the long data CRC.
// Assumes: clear is pulsed at frame start, inc once per popped byte.
module ftx_len_track #(
    parameter int CNT_W     = 8,
    parameter int SHORT_MAX = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic long_msg
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SHORT_MAX);

    logic [CNT_W-1:0] count;

    // Byte counter: clears per frame, saturates at all ones
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            count <= '0;
        else if (inc && (count != '1))
            count <= count + 1'b1;
    end

    // Long-message flag from the count
    always_comb long_msg = (count > LIMIT);

    // Within a frame the count never goes down
    AST_LEN_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> count >= $past(count));  // R5

endmodule

// File: rtl/frame_tx_packer.sv
// Module frame_tx_packer
// Serialises one data frame: bit sync, frame sync, four control bytes,
// user data from a FIFO, an optional length-dependent data CRC, and a
// single hang bit. Output is a valid/ready bit stream, MSB first.
// Assumes: the FIFO head (din) is stable while din_valid is high and no pop
// occurs; control inputs are sampled only on the start cycle.
module frame_tx_packer
    import ftx_pkg::*;
#(
    parameter logic [15:0] BIT_SYNC   = 16'hAAAA,
    parameter logic [15:0] FRAME_SYNC = 16'h3B28,
    parameter logic [15:0] CRC16_POLY = 16'h1021,
    parameter logic [31:0] CRC32_POLY = 32'h04C11DB7,
    parameter int          SHORT_MAX  = 16,
    parameter int          LEN_W      = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] addr_byte,
    input  logic [7:0] fmt_byte,
    input  logic [7:0] size_byte,
    input  logic       sized,
    input  logic       last_data,
    input  logic       irq_en,
    input  logic [7:0] din,
    input  logic       din_valid,
    output logic       din_ready,
    output logic       bit_out,
    output logic       bit_valid,
    input  logic       bit_ready,
    output logic       irq,
    output logic       underrun,
    output logic       busy
);
    localparam int FIELD_W = 32;
    localparam int CNT_W   = $clog2(FIELD_W + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIELD_W);
    localparam logic [CNT_W-1:0] BYTE_CNT = CNT_W'(8);
    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(16);

    ftx_state_e         state;
    logic [FIELD_W-1:0] shreg;
    logic [CNT_W-1:0]   bits_left;
    logic [FIELD_W-1:0] head_word;
    logic               sized_q;
    logic               last_bit;

    logic               xfer;
    logic               field_end;
    logic               need_byte;
    logic               frame_open;
    logic               crc_shift;
    logic               long_msg;
    logic [15:0]        crc16_q, crc16_nxt;
    logic [31:0]        crc32_q, crc32_nxt;

    // Handshake and boundary decode
    always_comb begin
        busy       = (state != ST_IDLE);
        bit_valid  = busy;
        bit_out    = (state == ST_HANG) ? ~last_bit : shreg[FIELD_W-1];
        xfer       = bit_valid && bit_ready;
        field_end  = xfer && (bits_left == CNT_W'(1));
        need_byte  = field_end && ((state == ST_HEAD) || (state == ST_DATA));
        din_ready  = need_byte && din_valid;
        frame_open = (state == ST_IDLE) && start;
        crc_shift  = xfer && (state == ST_DATA);
    end

    // Short and long data CRC engines run side by side on the data bits
    ftx_crc_serial #(.WIDTH(16), .POLY(CRC16_POLY), .INIT('1)) u_crc16 (
        .clk(clk), .rst_n(rst_n), .clear(frame_open), .shift_en(crc_shift),
        .bit_in(shreg[FIELD_W-1]), .crc(crc16_q), .crc_nxt(crc16_nxt));

    ftx_crc_serial #(.WIDTH(32), .POLY(CRC32_POLY), .INIT('1)) u_crc32 (
        .clk(clk), .rst_n(rst_n), .clear(frame_open), .shift_en(crc_shift),
        .bit_in(shreg[FIELD_W-1]), .crc(crc32_q), .crc_nxt(crc32_nxt));

    // Data byte count decides the CRC width
    ftx_len_track #(.CNT_W(LEN_W), .SHORT_MAX(SHORT_MAX)) u_len (
        .clk(clk), .rst_n(rst_n), .clear(frame_open), .inc(din_ready),
        .long_msg(long_msg));

    // Frame sequencer and field shifter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            shreg     <= '0;
            bits_left <= '0;
            head_word <= '0;
            sized_q   <= 1'b0;
            last_bit  <= 1'b0;
            underrun  <= 1'b0;
            irq       <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (xfer) begin
                last_bit  <= bit_out;
                shreg     <= {shreg[FIELD_W-2:0], 1'b0};
                bits_left <= bits_left - 1'b1;
            end
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state     <= ST_SYNC;
                        shreg     <= {BIT_SYNC, FRAME_SYNC};
                        bits_left <= FULL_CNT;
                        head_word <= {addr_byte, fmt_byte, size_byte,
                                      head_check(addr_byte, fmt_byte, size_byte)};
                        sized_q   <= sized;
                        underrun  <= 1'b0;
                    end
                end
                ST_SYNC: begin
                    if (field_end) begin
                        state     <= ST_HEAD;
                        shreg     <= head_word;
                        bits_left <= FULL_CNT;
                    end
                end
                ST_HEAD, ST_DATA: begin
                    if (field_end) begin
                        if (din_valid) begin
                            state     <= ST_DATA;
                            shreg     <= {din, 24'h0};
                            bits_left <= BYTE_CNT;
                        end else if (last_data && sized_q) begin
                            state     <= ST_CSUM;
                            shreg     <= long_msg ? crc32_nxt : {crc16_nxt, 16'h0};
                            bits_left <= long_msg ? FULL_CNT : HALF_CNT;
                        end else begin
                            state    <= ST_HANG;
                            underrun <= !last_data;
                        end
                    end
                end
                ST_CSUM: begin
                    if (field_end)
                        state <= ST_HANG;
                end
                ST_HANG: begin
                    if (xfer) begin
                        state <= ST_IDLE;
                        irq   <= irq_en;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // A stalled bit must not change before the modulator takes it
    AST_HOLD_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && !bit_ready) |=> (bit_valid && $stable(bit_out)));  // R9

    // The interrupt follows the hang state only
    AST_IRQ_AFTER_HANG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(state == ST_HANG));  // R7

    // The interrupt lasts one cycle
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);  // R7

    // An underrun frame never sends a data CRC
    AST_UNDERRUN_NO_CSUM: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (state != ST_CSUM));  // R8

    // A start during a frame leaves the latched control bytes alone
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(head_word));  // R10

endmodule

// File: tb/frame_tx_packer_test.sv
// Bench for frame_tx_packer: vector table of frames, then directed cases.
module frame_tx_packer_test;

    localparam logic [15:0] BS = 16'hAAAA;
    localparam logic [15:0] FS = 16'h3B28;
    // {addr, fmt, size, seed, nbytes, sized, ready_mode}
    localparam int NVEC = 6;
    localparam logic [47:0] VEC [NVEC] = '{
        {8'h3C, 8'h81, 8'h00, 8'h11, 8'd0,  4'd1, 4'd0},
        {8'hA5, 8'h02, 8'h05, 8'h40, 8'd5,  4'd1, 4'd1},
        {8'h01, 8'h10, 8'h10, 8'h7F, 8'd16, 4'd1, 4'd0},
        {8'hFF, 8'hFF, 8'h11, 8'hC3, 8'd17, 4'd1, 4'd2},
        {8'h55, 8'h00, 8'h9A, 8'h00, 8'd3,  4'd0, 4'd2},
        {8'h80, 8'h7E, 8'h01, 8'hEE, 8'd1,  4'd0, 4'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] addr_byte = '0, fmt_byte = '0, size_byte = '0;
    logic sized = 1'b0, last_data = 1'b0, irq_en = 1'b0;
    logic [7:0] din = '0;
    logic din_valid = 1'b0;
    logic din_ready, bit_out, bit_valid, irq, underrun, busy;
    logic bit_ready = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    int ready_mode = 0;
    int irq_cnt = 0;
    int hold_err = 0;
    logic prev_stall = 1'b0;
    logic prev_bit = 1'b0;
    logic pop_pend = 1'b0;
    logic [7:0] fifo_q[$];
    logic got_q[$];
    logic exp_q[$];
    logic [7:0] dbytes [64];

    always #4 clk = ~clk;  // 125 MHz

    frame_tx_packer uut (
        .clk(clk), .rst_n(rst_n), .start(start), .addr_byte(addr_byte),
        .fmt_byte(fmt_byte), .size_byte(size_byte), .sized(sized),
        .last_data(last_data), .irq_en(irq_en), .din(din),
        .din_valid(din_valid), .din_ready(din_ready), .bit_out(bit_out),
        .bit_valid(bit_valid), .bit_ready(bit_ready), .irq(irq),
        .underrun(underrun), .busy(busy));

    task automatic check(input bit ok, input string req,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Modulator and FIFO model: drive after negedge, observe 1 ns later
    always @(negedge clk) begin
        cyc++;
        if (pop_pend && fifo_q.size() > 0) void'(fifo_q.pop_front());
        pop_pend = 1'b0;
        case (ready_mode)
            1:       bit_ready = (cyc % 2) == 0;
            2:       bit_ready = (cyc % 3) != 0;
            default: bit_ready = 1'b1;
        endcase
        din_valid = fifo_q.size() > 0;
        din = din_valid ? fifo_q[0] : 8'h00;
        if (irq) irq_cnt++;
        #1;
        if (prev_stall && !(bit_valid && bit_out == prev_bit)) hold_err++;
        prev_stall = bit_valid && !bit_ready;
        prev_bit = bit_out;
        if (bit_valid && bit_ready) got_q.push_back(bit_out);
        if (din_ready) pop_pend = 1'b1;
    end

    function automatic logic [31:0] crc_ref(input int w, input logic [31:0] poly,
                                            input int n);
        logic [31:0] mask, c;
        logic fb;
        mask = (w == 32) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        c = mask;
        for (int i = 0; i < n; i++)
            for (int b = 7; b >= 0; b--) begin
                fb = c[w-1] ^ dbytes[i][b];
                c = (c << 1) & mask;
                if (fb) c = c ^ poly;
            end
        return c;
    endfunction

    function automatic longint field(input int pos, input int len);
        longint v = 0;
        for (int i = 0; i < len; i++)
            v = (v << 1) | ((pos + i < got_q.size()) ? longint'(got_q[pos+i]) : 0);
        return v;
    endfunction

    task automatic push_bits(input logic [31:0] v, input int len);
        for (int i = len - 1; i >= 0; i--) exp_q.push_back(v[i]);
    endtask

    task automatic run_frame(input logic [7:0] a, input logic [7:0] f,
                             input logic [7:0] s, input bit sz, input int n,
                             input logic [7:0] seed, input int rmode,
                             input bit ldata, input bit ien, input bit restart);
        logic [7:0] chk;
        int w, wait_c, mism;
        chk = 8'(0) - (a + f + s);
        exp_q.delete();
        push_bits({BS, FS}, 32);
        push_bits({a, f, s, chk}, 32);
        for (int i = 0; i < n; i++) begin
            dbytes[i] = seed + 8'(i * 37);
            push_bits({24'h0, dbytes[i]}, 8);
        end
        w = 0;
        if (sz && ldata) begin
            w = (n > 16) ? 32 : 16;
            push_bits(crc_ref(w, (w == 32) ? 32'h04C11DB7 : 32'h1021, n), w);
        end
        exp_q.push_back(~exp_q[$]);

        @(negedge clk);
        got_q.delete();
        irq_cnt = 0;
        hold_err = 0;
        for (int i = 0; i < n; i++) fifo_q.push_back(dbytes[i]);
        ready_mode = rmode;
        addr_byte = a; fmt_byte = f; size_byte = s;
        sized = sz; last_data = ldata; irq_en = ien;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_c = 0;
        while ((busy || wait_c < 2) && wait_c < 4000) begin
            @(negedge clk);
            wait_c++;
            if (restart && wait_c == 10) begin
                addr_byte = ~a; sized = ~sz; start = 1'b1;
            end else if (restart && wait_c == 11) begin
                start = 1'b0;
            end
        end
        @(negedge clk);
        @(negedge clk);

        check(got_q.size() >= 64 && field(0, 32) == longint'({BS, FS}),
              "R2 sync words", field(0, 32), longint'({BS, FS}));
        check(field(32, 8) == a && field(40, 8) == f && field(48, 8) == s &&
              8'(field(32, 8) + field(40, 8) + field(48, 8) + field(56, 8)) == 8'h00,
              "R3 control bytes", field(32, 32), longint'({a, f, s, chk}));
        mism = 0;
        foreach (exp_q[i]) if (i >= got_q.size() || got_q[i] !== exp_q[i]) mism++;
        check(mism == 0 && got_q.size() == exp_q.size(),
              (w == 0) ? "R4 data stream, no CRC" :
              ((w == 32) ? "R5 data plus 32-bit CRC" : "R5 data plus 16-bit CRC"),
              got_q.size(), exp_q.size());
        check(got_q.size() > 1 && got_q[got_q.size()-1] == ~got_q[got_q.size()-2]
              && !busy && !bit_valid, "R6 hang bit and stop",
              got_q.size() > 0 ? got_q[got_q.size()-1] : 0, exp_q[$]);
        check(irq_cnt == (ien ? 1 : 0), "R7 interrupt count", irq_cnt, ien ? 1 : 0);
        check(underrun == !ldata, "R8 underrun flag", underrun, !ldata);
        check(fifo_q.size() == 0, "R4 FIFO drained", fifo_q.size(), 0);
        if (rmode != 0)
            check(hold_err == 0, "R9 bit held while stalled", hold_err, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        #2;
        check(!bit_valid && !busy && !irq && !din_ready && !underrun,
              "R1 reset outputs", {bit_valid, busy, irq, din_ready, underrun}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        check(!bit_valid && !busy && !irq && !din_ready && !underrun,
              "R1 idle after reset", {bit_valid, busy, irq, din_ready, underrun}, 0);

        for (int v = 0; v < NVEC; v++)
            run_frame(VEC[v][47:40], VEC[v][39:32], VEC[v][31:24], VEC[v][4],
                      int'(VEC[v][15:8]), VEC[v][23:16], int'(VEC[v][3:0]),
                      1'b1, 1'b1, 1'b0);

        // R8: FIFO runs dry without last_data
        run_frame(8'h12, 8'h34, 8'h04, 1'b1, 4, 8'h5A, 1, 1'b0, 1'b1, 1'b0);
        // R7: interrupt disabled
        run_frame(8'h9C, 8'h03, 8'h02, 1'b1, 2, 8'h21, 0, 1'b1, 1'b0, 1'b0);
        // R10: start pulse mid-frame with different inputs
        run_frame(8'h6B, 8'h44, 8'h08, 1'b1, 8, 8'h90, 2, 1'b1, 1'b1, 1'b1);
        check(got_q.size() == exp_q.size(), "R10 restart ignored",
              got_q.size(), exp_q.size());

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule